// File: doc/BRIEF.md
# Closed Caption Line Encoder

This block produces the digital waveform for two caption channels carried in the vertical blanking interval of interlaced video. One channel carries caption text and the other carries extended data. Each channel holds a two-byte pair written by a host through a small byte-wide write port. On the video line assigned to a channel, the block emits a clock run-in, a start pattern and the sixteen data bits. The output is a stream of 10-bit sample codes, one code per pixel-slot strobe from the video timing logic.

A pair counts as fresh only once its second byte has been written. A channel whose pair is not fresh when its line arrives sends two null characters (code 0x80, which is the null character with its odd parity bit set). The host supplies the parity bit in bit 7 of every byte, and the block never computes parity. A per-channel ready output tells the host when a new pair may be loaded. A channel can be disabled, and a disabled channel leaves its line at the blanking level.

Top module: `cc_line_encoder`

## Requirements
- R1: After a synchronous reset, both ready outputs are 1, `cc_active` is 0 and `cc_level` equals the low code.
- R2: Writes use address 0 for the caption first byte, 1 for the caption second byte, 2 for the extended first byte and 3 for the extended second byte. A write to address 1 or 3 clears that channel's ready output at the same clock edge. A write to a first byte alone leaves ready unchanged.
- R3: When `line_start` marks the selected line of an enabled channel, the waveform begins after START_SLOT further `slot_tick` strobes. It opens with 7 run-in bit periods. In each run-in period, the first SLOTS_PER_BIT/2 slots are at the high code and the remaining slots are at the low code.
- R4: The run-in is followed by the start bits 0, 0 and 1, then 16 data bits. The data bits are the first byte then the second byte, each sent least significant bit first. Each bit lasts SLOTS_PER_BIT slots, a 1 is sent as the high code and a 0 as the low code.
- R5: If no second-byte write has arrived since the channel's previous transmission, the line carries the pair 0x80, 0x80.
- R6: Caption data is sent on line 21 in both standards. Extended data is sent on line 284 when `std625` is 0 and on line 334 when `std625` is 1.
- R7: A channel whose enable is 0 produces nothing on its line (`cc_active` stays 0), and its pending pair stays pending with ready at 0.
- R8: Ready returns to 1 at the edge of the slot strobe that ends the last data bit, provided no new second byte has been written since the line began.
- R9: The pair sent on a line is the one held when `line_start` arrived. Writes during the transmission do not change the waveform and are sent on the channel's next line.
- R10: A line number that matches no enabled channel produces no waveform.
- R11: Timing advances only on `slot_tick`. Between strobes, the output level and the position in the waveform hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte select: 0/1 caption first/second, 2/3 extended first/second |
| wr_data | input | 8 | Byte to write, parity in bit 7 |
| cap_en | input | 1 | Caption channel enable |
| ext_en | input | 1 | Extended data channel enable |
| std625 | input | 1 | 1 selects 625-line numbering for the extended line |
| line_start | input | 1 | One-cycle strobe at the sync of each line |
| line_num | input | 10 | Frame line number, valid with `line_start` |
| slot_tick | input | 1 | Pixel-slot strobe |
| ready_cap | output | 1 | Caption channel may take a new pair |
| ready_ext | output | 1 | Extended channel may take a new pair |
| cc_active | output | 1 | Waveform is being emitted |
| cc_level | output | 10 | Output sample code |

## Verification
The ready outputs respond at the clock edge that registers a write, so they are due in the cycle right after the write strobe. The waveform has no fixed latency in clocks. Its first slot appears after the edge of the START_SLOT-th slot strobe that follows the line strobe, and ready returns on the edge of the strobe that ends bit 25. The bench model counts the same strobes to decide where each output belongs and compares all four outputs after every falling edge. Some lines use gapped strobes so that position is tracked by strobes and not by clocks. The bench also captures the middle slot of each bit period and compares the assembled frame against the pair it wrote.

// File: rtl/cc_enc_pkg.sv
package cc_enc_pkg;

    localparam int RUNIN_BITS = 7;
    localparam int START_BITS = 3;
    localparam int DATA_BITS  = 16;
    localparam int FRAME_BITS = RUNIN_BITS + START_BITS + DATA_BITS;

    localparam int LINE_CAP     = 21;
    localparam int LINE_EXT_525 = 284;
    localparam int LINE_EXT_625 = 334;

    localparam logic [7:0] NULL_CHAR = 8'h80;

    typedef enum logic [1:0] {
        SER_IDLE,
        SER_WAIT,
        SER_SEND
    } ser_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } cc_pair_t;

    // Logical value of frame bit idx; first_half selects the run-in phase.
    function automatic logic frame_bit(input logic [4:0] idx,
                                       input logic       first_half,
                                       input cc_pair_t   p);
        logic [15:0] v;
        logic [4:0]  k;
        v = p;
        k = idx - 5'(RUNIN_BITS + START_BITS);
        if (idx < 5'(RUNIN_BITS))
            return first_half;
        else if (idx < 5'(RUNIN_BITS + START_BITS - 1))
            return 1'b0;
        else if (idx == 5'(RUNIN_BITS + START_BITS - 1))
            return 1'b1;
        else
            return v[k[3:0]];
    endfunction

endpackage

// File: rtl/cc_chan_regs.sv
module cc_chan_regs
    import cc_enc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_lo,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       take,
    input  logic       done,
    output cc_pair_t   pair_out,
    output logic       ready
);

    logic [7:0] lo_q, hi_q;
    logic       pend_q;
    logic       inflt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            pend_q  <= 1'b0;
            inflt_q <= 1'b0;
        end else begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) hi_q <= wr_data;
            if (take) begin
                inflt_q <= pend_q;
                pend_q  <= 1'b0;
            end else if (done) begin
                inflt_q <= 1'b0;
            end
            if (wr_hi) pend_q <= 1'b1;
        end
    end

    assign pair_out = pend_q ? cc_pair_t'{hi: hi_q, lo: lo_q}
                             : cc_pair_t'{hi: NULL_CHAR, lo: NULL_CHAR};
    assign ready    = !pend_q && !inflt_q;

endmodule

// File: rtl/cc_serializer.sv
module cc_serializer
    import cc_enc_pkg::*;
#(
    parameter int          SLOTS_PER_BIT = 54,
    parameter int          START_SLOT    = 270,
    parameter int          LVL_W         = 10,
    parameter logic [9:0]  LVL_LOW       = 10'd240,
    parameter logic [9:0]  LVL_HIGH      = 10'd520
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_start,
    input  logic             load,
    input  cc_pair_t         pair_in,
    input  logic             slot_tick,
    output logic             done,
    output logic             active,
    output logic [LVL_W-1:0] level
);

    localparam int SLOT_W = $clog2(START_SLOT + 1);
    localparam int PH_W   = $clog2(SLOTS_PER_BIT);
    localparam logic [4:0]      LAST_BIT = 5'(FRAME_BITS - 1);
    localparam logic [PH_W-1:0] LAST_PH  = PH_W'(SLOTS_PER_BIT - 1);
    localparam logic [PH_W-1:0] HALF_PH  = PH_W'(SLOTS_PER_BIT / 2);

    ser_state_e        state_q;
    logic [SLOT_W-1:0] slot_q;
    logic [PH_W-1:0]   phase_q;
    logic [4:0]        bit_q;
    cc_pair_t          pay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SER_IDLE;
            slot_q  <= '0;
            phase_q <= '0;
            bit_q   <= '0;
            pay_q   <= '0;
        end else if (line_start) begin
            state_q <= load ? SER_WAIT : SER_IDLE;
            slot_q  <= '0;
            phase_q <= '0;
            bit_q   <= '0;
            pay_q   <= pair_in;
        end else if (slot_tick) begin
            case (state_q)
                SER_WAIT: begin
                    if (slot_q == SLOT_W'(START_SLOT - 1))
                        state_q <= SER_SEND;
                    else
                        slot_q <= slot_q + 1'b1;
                end
                SER_SEND: begin
                    if (phase_q == LAST_PH) begin
                        phase_q <= '0;
                        if (bit_q == LAST_BIT)
                            state_q <= SER_IDLE;
                        else
                            bit_q <= bit_q + 1'b1;
                    end else begin
                        phase_q <= phase_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign done   = (state_q == SER_SEND) && slot_tick && !line_start &&
                    (phase_q == LAST_PH) && (bit_q == LAST_BIT);
    assign active = (state_q == SER_SEND);
    assign level  = (active && frame_bit(bit_q, phase_q < HALF_PH, pay_q))
                    ? LVL_HIGH[LVL_W-1:0] : LVL_LOW[LVL_W-1:0];

endmodule

// File: rtl/cc_line_encoder.sv
module cc_line_encoder
    import cc_enc_pkg::*;
#(
    parameter int          SLOTS_PER_BIT = 54,
    parameter int          START_SLOT    = 270,
    parameter int          LINE_W        = 10,
    parameter int          LVL_W         = 10,
    parameter logic [9:0]  LVL_LOW       = 10'd240,
    parameter logic [9:0]  LVL_HIGH      = 10'd520
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              cap_en,
    input  logic              ext_en,
    input  logic              std625,
    input  logic              line_start,
    input  logic [LINE_W-1:0] line_num,
    input  logic              slot_tick,
    output logic              ready_cap,
    output logic              ready_ext,
    output logic              cc_active,
    output logic [LVL_W-1:0]  cc_level
);

    localparam int NCH = 2;

    logic [NCH-1:0] hit_v, take_v, done_v, rdy_v;
    cc_pair_t       pair_v [NCH];
    logic           ch_q;
    logic           ser_done;
    cc_pair_t       pair_sel;

    assign hit_v[0] = cap_en && (line_num == LINE_W'(LINE_CAP));
    assign hit_v[1] = ext_en && (line_num == (std625 ? LINE_W'(LINE_EXT_625)
                                                     : LINE_W'(LINE_EXT_525)));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign take_v[c] = line_start && hit_v[c];
        assign done_v[c] = ser_done && (ch_q == 1'(c));
        cc_chan_regs u_regs (
            .clk      (clk),
            .rst      (rst),
            .wr_lo    (wr_en && wr_addr == {1'(c), 1'b0}),
            .wr_hi    (wr_en && wr_addr == {1'(c), 1'b1}),
            .wr_data  (wr_data),
            .take     (take_v[c]),
            .done     (done_v[c]),
            .pair_out (pair_v[c]),
            .ready    (rdy_v[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)             ch_q <= 1'b0;
        else if (line_start) ch_q <= hit_v[1];
    end

    assign pair_sel = hit_v[1] ? pair_v[1] : pair_v[0];

    cc_serializer #(
        .SLOTS_PER_BIT (SLOTS_PER_BIT),
        .START_SLOT    (START_SLOT),
        .LVL_W         (LVL_W),
        .LVL_LOW       (LVL_LOW),
        .LVL_HIGH      (LVL_HIGH)
    ) u_ser (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .load       (|hit_v),
        .pair_in    (pair_sel),
        .slot_tick  (slot_tick),
        .done       (ser_done),
        .active     (cc_active),
        .level      (cc_level)
    );

    assign ready_cap = rdy_v[0];
    assign ready_ext = rdy_v[1];

endmodule

// File: rtl/cc_line_encoder_chk.sv
module cc_line_encoder_chk #(
    parameter int         LVL_W    = 10,
    parameter logic [9:0] LVL_LOW  = 10'd240,
    parameter logic [9:0] LVL_HIGH = 10'd520
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             line_start,
    input logic             slot_tick,
    input logic             ready_cap,
    input logic             ready_ext,
    input logic             cc_active,
    input logic [LVL_W-1:0] cc_level
);

    assert_idle_low_R1: assert property (@(posedge clk) disable iff (rst)
        !cc_active |-> cc_level == LVL_LOW[LVL_W-1:0]);

    assert_cap_wr_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd1) |=> !ready_cap);

    assert_ext_wr_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd3) |=> !ready_ext);

    assert_wait_after_sync_R3: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !cc_active);

    assert_two_levels_R4: assert property (@(posedge clk) disable iff (rst)
        cc_level == LVL_HIGH[LVL_W-1:0] || cc_level == LVL_LOW[LVL_W-1:0]);

    assert_hold_no_tick_R11: assert property (@(posedge clk) disable iff (rst)
        (cc_active && !slot_tick && !line_start) |=> $stable(cc_level));

endmodule

bind cc_line_encoder cc_line_encoder_chk #(
    .LVL_W    (LVL_W),
    .LVL_LOW  (LVL_LOW),
    .LVL_HIGH (LVL_HIGH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .line_start (line_start),
    .slot_tick  (slot_tick),
    .ready_cap  (ready_cap),
    .ready_ext  (ready_ext),
    .cc_active  (cc_active),
    .cc_level   (cc_level)
);

// File: tb/cc_line_encoder_test.sv
module cc_line_encoder_test;

    localparam int CLK_PERIOD = 10;
    localparam int SPB        = 4;
    localparam int START      = 10;
    localparam int FRAME      = 26;
    localparam int ENDT       = START + FRAME * SPB;
    localparam int LINE_LEN   = 180;
    localparam logic [9:0] LO = 10'd240;
    localparam logic [9:0] HI = 10'd520;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       cap_en = 1'b1, ext_en = 1'b1, std625 = 1'b0;
    logic       line_start = 1'b0;
    logic [9:0] line_num = '0;
    logic       slot_tick = 1'b0;
    logic       ready_cap, ready_ext, cc_active;
    logic [9:0] cc_level;

    int nchk = 0, nfail = 0;
    bit cmp_on = 0;

    cc_line_encoder #(
        .SLOTS_PER_BIT (SPB),
        .START_SLOT    (START),
        .LVL_LOW       (LO),
        .LVL_HIGH      (HI)
    ) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_en(cap_en), .ext_en(ext_en), .std625(std625),
        .line_start(line_start), .line_num(line_num), .slot_tick(slot_tick),
        .ready_cap(ready_cap), .ready_ext(ready_ext),
        .cc_active(cc_active), .cc_level(cc_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int          t_m = 0;
    bit          mode_m = 0;
    int          ch_m = 0;
    bit          pend_m [2];
    bit          inflt_m [2];
    logic [7:0]  lo_m [2];
    logic [7:0]  hi_m [2];
    logic [15:0] pay_m = '0;

    always @(posedge clk) begin
        if (rst) begin
            t_m = 0; mode_m = 0; ch_m = 0;
            for (int c = 0; c < 2; c++) begin
                pend_m[c] = 0; inflt_m[c] = 0; lo_m[c] = 0; hi_m[c] = 0;
            end
        end else begin
            if (line_start) begin
                int sel;
                sel = -1;
                if (cap_en && line_num == 21) sel = 0;
                else if (ext_en && line_num == (std625 ? 334 : 284)) sel = 1;
                if (sel >= 0) begin
                    pay_m = pend_m[sel] ? {hi_m[sel], lo_m[sel]} : 16'h8080;
                    inflt_m[sel] = pend_m[sel];
                    pend_m[sel] = 0;
                    mode_m = 1; t_m = 0; ch_m = sel;
                end else begin
                    mode_m = 0;
                end
            end else if (mode_m && slot_tick) begin
                t_m++;
                if (t_m == ENDT) begin
                    mode_m = 0;
                    inflt_m[ch_m] = 0;
                end
            end
            if (wr_en) begin
                if (wr_addr[0]) begin
                    hi_m[wr_addr[1]] = wr_data;
                    pend_m[wr_addr[1]] = 1;
                end else begin
                    lo_m[wr_addr[1]] = wr_data;
                end
            end
        end
    end

    function automatic bit exp_active();
        return mode_m && t_m >= START;
    endfunction

    function automatic logic [9:0] exp_level();
        int idx, b, ph;
        bit v;
        if (!exp_active()) return LO;
        idx = t_m - START; b = idx / SPB; ph = idx % SPB;
        if (b < 7) v = (ph < SPB/2);
        else if (b < 9) v = 0;
        else if (b == 9) v = 1;
        else v = pay_m[b-10];
        return v ? HI : LO;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle comparison and mid-bit capture
    bit          saw_active = 0;
    logic [25:0] cap_bits = '0;

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(cc_level == exp_level(), "R3/R4/R11 level", cc_level, exp_level());
            chk(cc_active == exp_active(), "R6/R7/R10 active", cc_active, exp_active());
            chk(ready_cap == (!pend_m[0] && !inflt_m[0]), "R2/R8/R9 ready_cap",
                ready_cap, !pend_m[0] && !inflt_m[0]);
            chk(ready_ext == (!pend_m[1] && !inflt_m[1]), "R2/R8 ready_ext",
                ready_ext, !pend_m[1] && !inflt_m[1]);
            if (cc_active) saw_active = 1;
            if (cc_active && exp_active() && ((t_m - START) % SPB) == SPB/2)
                cap_bits[(t_m - START) / SPB] = (cc_level == HI);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic run_line(input int ln, input bit gaps);
        @(negedge clk);
        line_num = 10'(ln); line_start = 1; slot_tick = 0;
        saw_active = 0; cap_bits = '0;
        @(negedge clk);
        line_start = 0;
        for (int i = 0; i < LINE_LEN; i++) begin
            slot_tick = gaps ? (i % 3 != 2) : 1'b1;
            @(negedge clk);
        end
        slot_tick = 0;
    endtask

    task automatic frame_ok(input string tag, input logic [15:0] pair);
        logic [25:0] e;
        e = {pair, 1'b1, 2'b00, 7'b0};
        chk(saw_active, {tag, " line active"}, saw_active, 1);
        chk(cap_bits == e, {tag, " frame bits"}, cap_bits, e);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;
        chk(ready_cap && ready_ext && !cc_active && cc_level == LO,
            "R1 reset state", {ready_cap, ready_ext, cc_active}, 3'b110);
        rst = 0;

        // R2: first byte alone keeps ready, second byte clears it
        wr(2'd0, 8'hC1);
        chk(ready_cap == 1, "R2 first byte only", ready_cap, 1);
        wr(2'd1, 8'hC2);
        chk(ready_cap == 0, "R2 second byte", ready_cap, 0);

        run_line(21, 0);
        frame_ok("R3 R4 caption", 16'hC2C1);
        chk(ready_cap == 1, "R8 ready after line", ready_cap, 1);

        run_line(21, 0);
        frame_ok("R5 null pair", 16'h8080);

        // R6 in 525-line numbering
        wr(2'd2, 8'h20); wr(2'd3, 8'h52);
        run_line(334, 0);
        chk(!saw_active, "R6 ext absent on 334 in 525", saw_active, 0);
        chk(!ready_ext, "R6 ext still pending", ready_ext, 0);
        run_line(284, 0);
        frame_ok("R6 ext on 284", 16'h5220);
        chk(ready_ext == 1, "R8 ext ready", ready_ext, 1);

        // R6 in 625-line numbering, R11 gapped slot strobes
        std625 = 1;
        wr(2'd2, 8'h54); wr(2'd3, 8'h45);
        run_line(284, 0);
        chk(!saw_active, "R6 ext absent on 284 in 625", saw_active, 0);
        run_line(334, 1);
        frame_ok("R6 R11 ext on 334", 16'h4554);
        run_line(21, 1);
        frame_ok("R6 R11 caption on 21 in 625", 16'h8080);
        std625 = 0;

        // R7 disabled channel
        cap_en = 0;
        wr(2'd0, 8'h31); wr(2'd1, 8'h32);
        run_line(21, 0);
        chk(!saw_active, "R7 disabled silent", saw_active, 0);
        chk(!ready_cap, "R7 pair still pending", ready_cap, 0);
        cap_en = 1;
        run_line(21, 0);
        frame_ok("R7 sent after enable", 16'h3231);

        // R9 writes during transmission
        wr(2'd0, 8'h57); wr(2'd1, 8'h58);
        fork
            run_line(21, 0);
            begin
                repeat (50) @(negedge clk);
                wr(2'd0, 8'hD9); wr(2'd1, 8'hDA);
            end
        join
        frame_ok("R9 held pair", 16'h5857);
        chk(!ready_cap, "R9 new pair pending", ready_cap, 0);
        run_line(21, 0);
        frame_ok("R9 new pair next line", 16'hDAD9);

        // R10 unselected line
        wr(2'd0, 8'h31); wr(2'd1, 8'h32);
        run_line(22, 0);
        chk(!saw_active, "R10 line 22 silent", saw_active, 0);
        chk(!ready_cap, "R10 pair kept", ready_cap, 0);

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule